// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder/Subtractor

This block adds or subtracts two single-precision binary floating-point words. It registers the result, so each answer appears one clock after its operands. Each word holds a sign bit in bit 31, a biased exponent in bits 30..23 (bias 127) and a fraction in bits 22..0. Normal values carry an implied leading one. Subtraction is carried out by flipping the sign of the second operand and then adding.

Inside, the block puts the two operands in order by magnitude. It shifts the smaller significand right to line up the exponents, and it keeps three extra bits below the fraction: guard, round and sticky. It then adds or subtracts the significands. If there is a carry out, it shifts right by one. If there are leading zeros, it shifts left by their count. It rounds to nearest, ties to even, and renormalises if the rounding carries out.

Infinities, NaNs and zeros are detected on the way in and handled separately from the arithmetic path. Inputs with exponent field 0 are treated as zero. The block never produces a subnormal result. Two flag outputs report when a finite result overflowed to infinity or underflowed to zero.

Top module: `fp_addsub`

## Requirements
- R1: With `op_sub`=0 the output is the sum of two normal operands, rounded. When adding the significands carries out, the result is shifted right once and the exponent rises by one (1.5 + 2.5 gives 0x40800000).
- R2: The smaller operand is shifted right by the exponent difference. Every bit shifted past the round position is ORed into the sticky bit. A difference above 26 leaves only the sticky bit set.
- R3: If a finite result's biased exponent would reach 255, including after a rounding carry, the output is infinity with the result's sign and `ovf_o`=1. `ovf_o` and `unf_o` are never both 1.
- R4: In an effective subtraction, leading zeros are removed by a left shift and the exponent is lowered by the same count. A result that is exactly zero is +0 (0x00000000).
- R5: Rounding is to nearest. It rounds up when g=1 and (r|s)=1. On an exact tie (g=1, r=s=0) it rounds up only when the fraction LSB is 1.
- R6: If rounding carries out of the 24-bit significand, the result becomes 1.0 times 2 to the power of the exponent plus one.
- R7: If either input is a NaN (exponent 255, fraction not 0), or the operation is a difference of same-signed infinities, the output is a NaN (exponent 255, fraction not 0).
- R8: An infinite input with no NaN case gives an infinite output. Its sign is the operand's effective sign, which for the second operand is its sign XOR `op_sub`. `ovf_o` stays 0.
- R9: An input with exponent field 0 is taken as a zero of its sign. With one zero input, the output is the other operand with its effective sign. With two zero inputs, the output is -0 only if both effective signs are negative.
- R10: If the final biased exponent would be 0 or below, the output is a zero carrying the result's sign and `unf_o`=1. No output ever has exponent 0 with a nonzero fraction.
- R11: The result and flags are registered. They change only at a rising `clk` edge and show the operands present at that edge. While `rst_n`=0 they are all 0.
- R12: The sign of a nonzero finite result is the effective sign of the operand with the larger magnitude (3.0 - 5.0 gives 0xC0000000).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| op_sub | input | 1 | 1 selects op_a - op_b, 0 selects op_a + op_b |
| sum_o | output | 32 | Rounded result |
| ovf_o | output | 1 | Finite result overflowed to infinity |
| unf_o | output | 1 | Result underflowed and was flushed to zero |

## Verification
The bench targets rounding at its edges: exact ties with both fraction LSB values, and a sticky bit that turns a tie into a round-up. A design that mishandles these is off by one unit in the last place. It checks a rounding carry that moves the exponent, both in mid-range and at the top of the range. Missing the renormalisation there gives a fraction of zero with the wrong exponent, or a finite value where infinity belongs. It checks deep cancellation and differences far larger than the significand width. A broken leading-zero count or sticky bit gives a wrongly scaled or wrongly rounded result. It also covers NaN and infinity combinations, flushed subnormal inputs and underflow to a signed zero. A design that got these wrong would let arithmetic leak into the special cases, or would emit a subnormal or a wrongly signed zero.

// File: rtl/fp_addsub.sv
module fp_addsub #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [EXP_W+FRAC_W:0]   op_a,
  input  logic [EXP_W+FRAC_W:0]   op_b,
  input  logic                    op_sub,
  output logic [EXP_W+FRAC_W:0]   sum_o,
  output logic                    ovf_o,
  output logic                    unf_o
);
  localparam int WORD_W  = EXP_W + FRAC_W + 1;
  localparam int MW      = FRAC_W + 1;
  localparam int EXT_W   = MW + 3;
  localparam int SH_W    = $clog2(EXT_W + 1);
  localparam int XW      = EXP_W + 2;
  localparam logic [EXP_W-1:0]      EXP_ONES = {EXP_W{1'b1}};
  localparam logic signed [XW-1:0]  EMAX_S   = {2'b00, EXP_ONES};
  localparam logic [WORD_W-1:0]     QNAN     = {1'b0, EXP_ONES, 1'b1, {(FRAC_W-1){1'b0}}};

  logic              sa, sb;
  logic [EXP_W-1:0]  ea, eb;
  logic [FRAC_W-1:0] fa, fb;
  assign sa = op_a[WORD_W-1];
  assign sb = op_b[WORD_W-1] ^ op_sub;
  assign ea = op_a[WORD_W-2:FRAC_W];
  assign eb = op_b[WORD_W-2:FRAC_W];
  assign fa = op_a[FRAC_W-1:0];
  assign fb = op_b[FRAC_W-1:0];

  logic a_zero, b_zero, a_inf, b_inf, a_nan, b_nan;
  assign a_zero = (ea == '0);
  assign b_zero = (eb == '0);
  assign a_inf  = (ea == EXP_ONES) && (fa == '0);
  assign b_inf  = (eb == EXP_ONES) && (fb == '0);
  assign a_nan  = (ea == EXP_ONES) && (fa != '0);
  assign b_nan  = (eb == EXP_ONES) && (fb != '0);

  logic              swap, eff_sub, s_big;
  logic [EXP_W-1:0]  e_big, e_sml, diff;
  logic [FRAC_W-1:0] f_big, f_sml;
  assign swap    = op_b[WORD_W-2:0] > op_a[WORD_W-2:0];
  assign eff_sub = sa ^ sb;
  assign s_big   = swap ? sb : sa;
  assign e_big   = swap ? eb : ea;
  assign e_sml   = swap ? ea : eb;
  assign f_big   = swap ? fb : fa;
  assign f_sml   = swap ? fa : fb;
  assign diff    = e_big - e_sml;

  logic [SH_W-1:0]  sh;
  logic [EXT_W-1:0] big_x, sml_x, shifted, lost_mask, aligned;
  logic             lost;
  assign sh        = (diff > EXP_W'(EXT_W)) ? SH_W'(EXT_W) : diff[SH_W-1:0];
  assign big_x     = {1'b1, f_big, 3'b000};
  assign sml_x     = {1'b1, f_sml, 3'b000};
  assign shifted   = sml_x >> sh;
  assign lost_mask = ({{(EXT_W-1){1'b0}}, 1'b1} << sh) - 1'b1;
  assign lost      = |(sml_x & lost_mask);
  assign aligned   = {shifted[EXT_W-1:1], shifted[0] | lost};

  logic [EXT_W:0] sum_w;
  assign sum_w = eff_sub ? ({1'b0, big_x} - {1'b0, aligned})
                         : ({1'b0, big_x} + {1'b0, aligned});

  logic            carry;
  logic [SH_W-1:0] lz;
  assign carry = sum_w[EXT_W];

  always_comb begin
    logic found;
    found = 1'b0;
    lz    = '0;
    for (int i = EXT_W - 1; i >= 0; i--) begin
      if (!found && sum_w[i]) begin
        lz    = SH_W'(EXT_W - 1 - i);
        found = 1'b1;
      end
    end
    if (carry) lz = '0;
  end

  logic [EXT_W-1:0] norm;
  assign norm = carry ? {sum_w[EXT_W:2], sum_w[1] | sum_w[0]}
                      : (sum_w[EXT_W-1:0] << lz);

  logic [MW-1:0]     mant;
  logic              g_b, r_b, s_b, inc, rcarry;
  logic [MW:0]       rnd;
  logic [FRAC_W-1:0] frac_out;
  assign mant     = norm[EXT_W-1:3];
  assign g_b      = norm[2];
  assign r_b      = norm[1];
  assign s_b      = norm[0];
  assign inc      = g_b & (r_b | s_b | mant[0]);
  assign rnd      = {1'b0, mant} + {{MW{1'b0}}, inc};
  assign rcarry   = rnd[MW];
  assign frac_out = rcarry ? '0 : rnd[FRAC_W-1:0];

  logic signed [XW-1:0] exp_fin;
  assign exp_fin = $signed({2'b00, e_big})
                 + $signed({{(XW-1){1'b0}}, carry})
                 + $signed({{(XW-1){1'b0}}, rcarry})
                 - $signed({{(XW-SH_W){1'b0}}, lz});

  logic [WORD_W-1:0] res_d;
  logic              ovf_d, unf_d;

  always_comb begin
    res_d = '0;
    ovf_d = 1'b0;
    unf_d = 1'b0;
    if (a_nan || b_nan || (a_inf && b_inf && eff_sub))
      res_d = QNAN;
    else if (a_inf)
      res_d = {sa, EXP_ONES, {FRAC_W{1'b0}}};
    else if (b_inf)
      res_d = {sb, EXP_ONES, {FRAC_W{1'b0}}};
    else if (a_zero && b_zero)
      res_d = {sa & sb, {(WORD_W-1){1'b0}}};
    else if (a_zero)
      res_d = {sb, op_b[WORD_W-2:0]};
    else if (b_zero)
      res_d = op_a;
    else if (sum_w == '0)
      res_d = '0;
    else if (exp_fin >= EMAX_S) begin
      res_d = {s_big, EXP_ONES, {FRAC_W{1'b0}}};
      ovf_d = 1'b1;
    end else if (exp_fin[XW-1] || exp_fin == '0) begin
      res_d = {s_big, {(WORD_W-1){1'b0}}};
      unf_d = 1'b1;
    end else
      res_d = {s_big, exp_fin[EXP_W-1:0], frac_out};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_o <= '0;
      ovf_o <= 1'b0;
      unf_o <= 1'b0;
    end else begin
      sum_o <= res_d;
      ovf_o <= ovf_d;
      unf_o <= unf_d;
    end
  end

  logic started;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) started <= 1'b0;
    else        started <= 1'b1;
  end

  p_ovf_inf_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |-> (sum_o[WORD_W-2:FRAC_W] == EXP_ONES && sum_o[FRAC_W-1:0] == '0));

  p_flags_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf_o && unf_o));

  p_nan_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (started && $past(a_nan || b_nan)) |->
      (sum_o[WORD_W-2:FRAC_W] == EXP_ONES && sum_o[FRAC_W-1:0] != '0));

  p_unf_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    unf_o |-> (sum_o[WORD_W-2:0] == '0));

  p_no_subnormal_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sum_o[WORD_W-2:FRAC_W] == '0) |-> (sum_o[FRAC_W-1:0] == '0));

  p_self_cancel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (started && $past(op_sub && op_a == op_b && op_a[WORD_W-2:FRAC_W] != EXP_ONES))
      |-> (sum_o == '0 && !ovf_o && !unf_o));
endmodule

// File: tb/test_fp_addsub.sv
module test_fp_addsub;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic        op_sub = 1'b0;
  logic [31:0] sum_o;
  logic        ovf_o, unf_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  fp_addsub i_fp_addsub (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_sub(op_sub),
    .sum_o(sum_o), .ovf_o(ovf_o), .unf_o(unf_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] a, input logic [31:0] b,
                       input logic s, input logic [31:0] exp_r, input logic exp_o,
                       input logic exp_u);
    @(negedge clk);
    op_a = a; op_b = b; op_sub = s;
    @(negedge clk);
    n_chk++;
    if (sum_o !== exp_r || ovf_o !== exp_o || unf_o !== exp_u) begin
      n_bad++;
      $display("FAIL %s: %h %s %h got %h ovf=%b unf=%b expected %h ovf=%b unf=%b",
               tag, a, s ? "-" : "+", b, sum_o, ovf_o, unf_o, exp_r, exp_o, exp_u);
    end
  endtask

  task automatic check_nan(input string tag, input logic [31:0] a, input logic [31:0] b,
                           input logic s);
    @(negedge clk);
    op_a = a; op_b = b; op_sub = s;
    @(negedge clk);
    n_chk++;
    if (sum_o[30:23] !== 8'hFF || sum_o[22:0] == '0 || ovf_o !== 1'b0) begin
      n_bad++;
      $display("FAIL %s: got %h ovf=%b expected a NaN ovf=0", tag, sum_o, ovf_o);
    end
  endtask

  task automatic t_reset_and_latency;
    op_a = 32'h3F800000; op_b = 32'h3F800000;
    repeat (3) @(negedge clk);
    n_chk++;
    if (sum_o !== '0 || ovf_o !== 1'b0 || unf_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R11 reset: got %h/%b/%b expected 00000000/0/0", sum_o, ovf_o, unf_o);
    end
    rst_n = 1'b1;
    @(negedge clk);
    op_a = 32'h40400000; op_b = 32'h3F800000;
    #1;
    n_chk++;
    if (sum_o !== 32'h40000000) begin
      n_bad++;
      $display("FAIL R11 hold before edge: got %h expected 40000000", sum_o);
    end
    @(negedge clk);
    n_chk++;
    if (sum_o !== 32'h40800000) begin
      n_bad++;
      $display("FAIL R11 one-cycle latency: got %h expected 40800000", sum_o);
    end
  endtask

  task automatic t_plain_add;
    check("R1 1+1", 32'h3F800000, 32'h3F800000, 1'b0, 32'h40000000, 1'b0, 1'b0);
    check("R1 1.5+2.5", 32'h3FC00000, 32'h40200000, 1'b0, 32'h40800000, 1'b0, 1'b0);
  endtask

  task automatic t_sign;
    check("R12 3-5", 32'h40400000, 32'h40A00000, 1'b1, 32'hC0000000, 1'b0, 1'b0);
    check("R12 -1+0.5", 32'hBF800000, 32'h3F000000, 1'b0, 32'hBF000000, 1'b0, 1'b0);
  endtask

  task automatic t_cancel;
    check("R4 1-1", 32'h3F800000, 32'h3F800000, 1'b1, 32'h00000000, 1'b0, 1'b0);
    check("R4 -1-(-1)", 32'hBF800000, 32'hBF800000, 1'b1, 32'h00000000, 1'b0, 1'b0);
    check("R4 deep cancel", 32'h3F800001, 32'h3F800000, 1'b1, 32'h34000000, 1'b0, 1'b0);
  endtask

  task automatic t_sticky;
    check("R2 far add", 32'h3F800000, 32'h30800000, 1'b0, 32'h3F800000, 1'b0, 1'b0);
    check("R2 far sub", 32'h3F800000, 32'h30800000, 1'b1, 32'h3F800000, 1'b0, 1'b0);
    check("R2 sticky breaks tie", 32'h3F800000, 32'h33800001, 1'b0, 32'h3F800001, 1'b0, 1'b0);
  endtask

  task automatic t_tie;
    check("R5 tie even stays", 32'h3F800000, 32'h33800000, 1'b0, 32'h3F800000, 1'b0, 1'b0);
    check("R5 tie odd rounds up", 32'h3F800001, 32'h33800000, 1'b0, 32'h3F800002, 1'b0, 1'b0);
  endtask

  task automatic t_round_carry;
    check("R6 carry to 2.0", 32'h3FFFFFFF, 32'h33800000, 1'b0, 32'h40000000, 1'b0, 1'b0);
  endtask

  task automatic t_overflow;
    check("R3 max+max", 32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, 32'h7F800000, 1'b1, 1'b0);
    check("R3 -max-max", 32'hFF7FFFFF, 32'hFF7FFFFF, 1'b0, 32'hFF800000, 1'b1, 1'b0);
    check("R3 round carry overflow", 32'h7F7FFFFF, 32'h73000000, 1'b0, 32'h7F800000, 1'b1, 1'b0);
  endtask

  task automatic t_nan;
    check_nan("R7 nan+1", 32'h7FC00000, 32'h3F800000, 1'b0);
    check_nan("R7 1-nan", 32'h3F800000, 32'hFF800001, 1'b1);
    check_nan("R7 inf-inf", 32'h7F800000, 32'h7F800000, 1'b1);
    check_nan("R7 inf+-inf", 32'h7F800000, 32'hFF800000, 1'b0);
  endtask

  task automatic t_inf;
    check("R8 inf+1", 32'h7F800000, 32'h3F800000, 1'b0, 32'h7F800000, 1'b0, 1'b0);
    check("R8 1-inf", 32'h3F800000, 32'h7F800000, 1'b1, 32'hFF800000, 1'b0, 1'b0);
    check("R8 -inf+-inf", 32'hFF800000, 32'hFF800000, 1'b0, 32'hFF800000, 1'b0, 1'b0);
  endtask

  task automatic t_flush;
    check("R9 subnormal+1", 32'h00000001, 32'h3F800000, 1'b0, 32'h3F800000, 1'b0, 1'b0);
    check("R9 sub+sub", 32'h00400000, 32'h00400000, 1'b0, 32'h00000000, 1'b0, 1'b0);
    check("R9 -0+-0", 32'h80000000, 32'h80000000, 1'b0, 32'h80000000, 1'b0, 1'b0);
    check("R9 0-2", 32'h00000000, 32'h40000000, 1'b1, 32'hC0000000, 1'b0, 1'b0);
  endtask

  task automatic t_underflow;
    check("R10 tiny diff", 32'h00800001, 32'h00800000, 1'b1, 32'h00000000, 1'b0, 1'b1);
    check("R10 neg underflow", 32'h80C00000, 32'h80800000, 1'b1, 32'h80000000, 1'b0, 1'b1);
    check("R10 min normal kept", 32'h01000000, 32'h00800000, 1'b1, 32'h00800000, 1'b0, 1'b0);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    t_reset_and_latency();
    t_plain_add();
    t_sign();
    t_cancel();
    t_sticky();
    t_tie();
    t_round_carry();
    t_overflow();
    t_nan();
    t_inf();
    t_flush();
    t_underflow();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got a hung run expected completion");
      summary();
      $finish;
    end
  end
endmodule